// File: doc/BRIEF.md
# Parallel CPU-Interface Panel Writer

This block streams one frame of pixels to a command-mode LCD panel over an 8080-style parallel bus. The bus has an active-low chip select, an active-low write strobe and a data bus. Pixels arrive from an upstream FIFO through a valid/ready handshake. Each pixel becomes one bus write. Every write is shaped by four programmable timing fields: chip-select setup, write setup, write-active width and write hold.

A frame is launched by a trigger, and each trigger produces exactly one frame. In software mode the trigger is a self-clearing command bit in the trigger control word. In hardware mode the trigger is the rising edge of the panel's tearing-effect (TE) input. Any trigger that arrives while a frame is still being written is discarded, because repeated triggers can upset the panel. When the last pixel of the frame has gone out, the block returns to idle and pulses a frame-done interrupt for one cycle.

Top module: `cpu_panel_writer`

## Requirements
- R1: After reset, csN and wrN are high, frameIrq and pixReady are low, and the timing register holds interface disabled, CS setup 0, WR setup 0, WR active 1 and WR hold 0.
- R2: Bit 0 of the configuration word enables the interface. While it is clear, no trigger starts a frame, pixReady stays low and csN never falls.
- R3: Configuration word fields: CS setup in bits 19:16, WR setup in 15:12, WR active in 11:8 and WR hold in 7:4, each a count of clock cycles. Each write keeps csN low for CS setup + WR setup + max(WR active,1) + WR hold cycles. wrN falls CS setup + WR setup cycles after csN falls and stays low for max(WR active,1) cycles. csN rises WR hold cycles after wrN rises. wrN is never low while csN is high. busData holds the accepted pixel, unchanged, while csN is low.
- R4: pixReady is high only while the bus is idle inside a frame with the interface enabled. Each handshake gives exactly one write. Between consecutive writes csN is high for exactly one cycle when pixValid stays high. No write starts while pixValid is low.
- R5: A frame has colCount × lineCount writes, with each count taken at face value and required to be at least 1.
- R6: In the trigger word, bit 0 selects software trigger mode and bit 1 is the trigger command. Writing both bits set, outside hardware mode, starts a frame.
- R7: The trigger command bit clears itself, so one command write produces exactly one frame.
- R8: Hardware mode is selected when trigger-word bits 3 and 4 are both set. In that mode a rising edge on teIn starts a frame, software commands are ignored, and a TE level held high does not start another frame.
- R9: A trigger of either kind that arrives while a frame is in progress is dropped and does not queue a later frame.
- R10: frameIrq is high for exactly one cycle per frame. That cycle is the first cycle with csN high after the frame's last write.
- R11: A trigger command written with bit 0 clear and hardware mode not selected starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the timing configuration word |
| cfgWdata | input | 20 | Timing configuration word |
| trigWe | input | 1 | Write strobe for the trigger control word |
| trigWdata | input | 5 | Trigger control word |
| colCount | input | CNT_W | Pixels per line |
| lineCount | input | CNT_W | Lines per frame |
| teIn | input | 1 | Tearing-effect input from the panel (asynchronous) |
| pixValid | input | 1 | Upstream pixel valid |
| pixData | input | DATA_W | Upstream pixel data |
| pixReady | output | 1 | Pixel accepted when high together with pixValid |
| csN | output | 1 | Panel chip select, active low |
| wrN | output | 1 | Panel write strobe, active low |
| busData | output | DATA_W | Panel data bus |
| frameIrq | output | 1 | One-cycle frame-done interrupt |

## Verification
The bench builds the block with an 8-bit data path and 4-bit column and line counters. With these values the frames are small enough for whole transfers, including every phase at its largest value of 15 cycles, to finish in a few hundred cycles. Because of this, the 60-cycle maximum write and the all-zero timing case (where write-active is raised to one cycle) can both be measured edge by edge. The short frames also make it cheap to fire repeated triggers in the middle of a frame and then confirm that no extra frame follows.

// File: rtl/cpw_pkg.sv
`timescale 1ns/1ps
package cpw_pkg;
  localparam int TFW = 4;

  typedef struct packed {
    logic           enable;
    logic [TFW-1:0] csSetup;
    logic [TFW-1:0] wrSetup;
    logic [TFW-1:0] wrActive;
    logic [TFW-1:0] wrHold;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT, PH_CSSU, PH_WRSU, PH_ACT, PH_HOLD
  } phase_t;

  typedef struct packed {
    logic csLow;
    logic wrLow;
    logic loadPix;
  } busStrobe_t;

  typedef struct packed {
    phase_t         ph;
    logic [TFW-1:0] cnt;
    logic           done;
  } phaseLoad_t;

  // Enter phase 'from', skipping any phase whose length is zero.
  function automatic phaseLoad_t seekPhase(input phase_t from, input timing_t t);
    phaseLoad_t r;
    r.ph   = from;
    r.cnt  = '0;
    r.done = 1'b0;
    if (r.ph == PH_CSSU) begin
      if (t.csSetup != '0) r.cnt = t.csSetup - 4'd1;
      else                 r.ph  = PH_WRSU;
    end
    if (r.ph == PH_WRSU) begin
      if (t.wrSetup != '0) r.cnt = t.wrSetup - 4'd1;
      else                 r.ph  = PH_ACT;
    end
    if (r.ph == PH_ACT) begin
      r.cnt = (t.wrActive != '0) ? t.wrActive - 4'd1 : '0;
    end
    if (r.ph == PH_HOLD) begin
      if (t.wrHold != '0) r.cnt  = t.wrHold - 4'd1;
      else                r.done = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/cpw_datapath.sv
`timescale 1ns/1ps
module cpw_datapath
  import cpw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [19:0]       cfgWdata,
  input  busStrobe_t        strb,
  input  logic [DATA_W-1:0] pixData,
  output timing_t           tim,
  output logic              csN,
  output logic              wrN,
  output logic [DATA_W-1:0] busData
);
  logic unusedCfgBits;
  assign unusedCfgBits = ^cfgWdata[3:1];

  // Timing register: field positions fixed by the configuration word layout.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tim <= '{enable: 1'b0, csSetup: '0, wrSetup: '0, wrActive: 4'd1, wrHold: '0};
    end else if (cfgWe) begin
      tim <= '{enable:   cfgWdata[0],
               csSetup:  cfgWdata[19:16],
               wrSetup:  cfgWdata[15:12],
               wrActive: cfgWdata[11:8],
               wrHold:   cfgWdata[7:4]};
    end
  end

  // Bus pins registered from next-phase strobes: glitch-free, no added lag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= 1'b1;
      wrN     <= 1'b1;
      busData <= '0;
    end else begin
      csN <= ~strb.csLow;
      wrN <= ~strb.wrLow;
      if (strb.loadPix) busData <= pixData;
    end
  end

  p_wr_in_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !csN);

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(busData));

  p_cs_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(tim.enable));
endmodule

// File: rtl/cpw_ctrl.sv
`timescale 1ns/1ps
module cpw_ctrl
  import cpw_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  timing_t          tim,
  input  logic             trigWe,
  input  logic [4:0]       trigWdata,
  input  logic [CNT_W-1:0] colCount,
  input  logic [CNT_W-1:0] lineCount,
  input  logic             teIn,
  input  logic             pixValid,
  output logic             pixReady,
  output busStrobe_t       strb,
  output logic             frameIrq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_t           phase, nextPh;
  logic [TFW-1:0]   cnt, nextCnt;
  logic [CNT_W-1:0] colIdx, lineIdx;
  logic             swMode, swCmd, hwEn, hwMask;
  logic             teS1, teS2, teQ;
  logic             hwMode, teRise, startReq, start, hs, lastPix, wrDone;
  phaseLoad_t       ld;
  logic             unusedTrigBit;

  assign unusedTrigBit = trigWdata[2];

  assign hwMode   = hwEn & hwMask;
  assign teRise   = teS2 & ~teQ;
  assign startReq = hwMode ? teRise : (swMode & swCmd);
  assign start    = (phase == PH_IDLE) && tim.enable && startReq;
  assign pixReady = (phase == PH_WAIT) && tim.enable;
  assign hs       = pixReady && pixValid;
  assign lastPix  = (colIdx == colCount - CNT_ONE) && (lineIdx == lineCount - CNT_ONE);

  always_comb begin
    nextPh  = phase;
    nextCnt = cnt;
    wrDone  = 1'b0;
    ld      = '0;
    unique case (phase)
      PH_IDLE: if (start) nextPh = PH_WAIT;
      PH_WAIT: if (hs) begin
        ld      = seekPhase(PH_CSSU, tim);
        nextPh  = ld.ph;
        nextCnt = ld.cnt;
      end
      PH_CSSU, PH_WRSU, PH_ACT: begin
        if (cnt != '0) nextCnt = cnt - 4'd1;
        else begin
          ld = seekPhase((phase == PH_CSSU) ? PH_WRSU :
                         (phase == PH_WRSU) ? PH_ACT : PH_HOLD, tim);
          if (ld.done) wrDone = 1'b1;
          else begin
            nextPh  = ld.ph;
            nextCnt = ld.cnt;
          end
        end
      end
      PH_HOLD: begin
        if (cnt != '0) nextCnt = cnt - 4'd1;
        else           wrDone  = 1'b1;
      end
      default: nextPh = PH_IDLE;
    endcase
    if (wrDone) begin
      nextPh  = lastPix ? PH_IDLE : PH_WAIT;
      nextCnt = '0;
    end
  end

  always_comb begin
    strb.csLow   = (nextPh == PH_CSSU) || (nextPh == PH_WRSU) ||
                   (nextPh == PH_ACT)  || (nextPh == PH_HOLD);
    strb.wrLow   = (nextPh == PH_ACT);
    strb.loadPix = hs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      colIdx   <= '0;
      lineIdx  <= '0;
      frameIrq <= 1'b0;
    end else begin
      phase    <= nextPh;
      cnt      <= nextCnt;
      frameIrq <= wrDone && lastPix;
      if (start) begin
        colIdx  <= '0;
        lineIdx <= '0;
      end else if (wrDone) begin
        if (colIdx == colCount - CNT_ONE) begin
          colIdx  <= '0;
          lineIdx <= lineIdx + CNT_ONE;
        end else begin
          colIdx <= colIdx + CNT_ONE;
        end
      end
    end
  end

  // Trigger control word; the command bit is consumed the cycle after it is set.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swMode <= 1'b0;
      swCmd  <= 1'b0;
      hwEn   <= 1'b0;
      hwMask <= 1'b0;
    end else if (trigWe) begin
      swMode <= trigWdata[0];
      swCmd  <= trigWdata[1];
      hwEn   <= trigWdata[3];
      hwMask <= trigWdata[4];
    end else if (swCmd) begin
      swCmd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      teS1 <= 1'b0;
      teS2 <= 1'b0;
      teQ  <= 1'b0;
    end else begin
      teS1 <= teIn;
      teS2 <= teS1;
      teQ  <= teS2;
    end
  end

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |=> !frameIrq);

  p_irq_ends_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> (phase == PH_IDLE));

  p_busy_drops_trig_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && startReq) |=> (phase != PH_WAIT) || $past(phase == PH_WAIT) || $past(wrDone));
endmodule

// File: rtl/cpu_panel_writer.sv
`timescale 1ns/1ps
module cpu_panel_writer
  import cpw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [19:0]       cfgWdata,
  input  logic              trigWe,
  input  logic [4:0]        trigWdata,
  input  logic [CNT_W-1:0]  colCount,
  input  logic [CNT_W-1:0]  lineCount,
  input  logic              teIn,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixReady,
  output logic              csN,
  output logic              wrN,
  output logic [DATA_W-1:0] busData,
  output logic              frameIrq
);
  timing_t    tim;
  busStrobe_t strb;

  cpw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tim(tim), .trigWe(trigWe), .trigWdata(trigWdata),
    .colCount(colCount), .lineCount(lineCount), .teIn(teIn),
    .pixValid(pixValid), .pixReady(pixReady), .strb(strb), .frameIrq(frameIrq)
  );

  cpw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .strb(strb),
    .pixData(pixData), .tim(tim), .csN(csN), .wrN(wrN), .busData(busData)
  );

  p_ready_bus_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> csN);
endmodule

// File: tb/cpu_panel_writer_test.sv
`timescale 1ns/1ps
module cpu_panel_writer_test;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [19:0]   cfgWdata = '0;
  logic          trigWe = 1'b0;
  logic [4:0]    trigWdata = '0;
  logic [CW-1:0] colCount = 4'd1;
  logic [CW-1:0] lineCount = 4'd1;
  logic          teIn = 1'b0;
  logic          pixValid = 1'b1;
  logic [DW-1:0] pixData;
  logic          pixReady, csN, wrN, frameIrq;
  logic [DW-1:0] busData;
  logic [DW-1:0] srcCnt;

  int nChecks = 0, nFail = 0;
  int writes = 0, irqCnt = 0, hsCnt = 0, readyErr = 0, irqBad = 0, dataBad = 0, unstable = 0;
  int csRun = 0, wrRun = 0, lead = 0, highRun = 0, gapNow = 0;
  int lastCs = 0, lastWr = 0, lastLead = 0, lastTail = 0, lastGap = 0;
  bit leadSet = 0;
  logic prevCs = 1'b1;
  logic [DW-1:0] dataAtFall = '0, expData = '0;

  always #2 clk = ~clk;

  cpu_panel_writer #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .trigWe(trigWe),
    .trigWdata(trigWdata), .colCount(colCount), .lineCount(lineCount), .teIn(teIn),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady), .csN(csN),
    .wrN(wrN), .busData(busData), .frameIrq(frameIrq)
  );

  assign pixData = srcCnt;
  always @(posedge clk) begin
    if (!rstN) srcCnt <= '0;
    else if (pixValid && pixReady) srcCnt <= srcCnt + 8'd1;
  end

  // Bus monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (pixReady && !csN) readyErr++;
      if (pixValid && pixReady) hsCnt++;
      if (frameIrq) begin
        irqCnt++;
        if (!(prevCs == 1'b0 && csN == 1'b1)) irqBad++;
      end
      if (!csN) begin
        if (prevCs) begin
          csRun = 0; wrRun = 0; lead = 0; leadSet = 0;
          gapNow = highRun; dataAtFall = busData;
        end
        csRun++;
        if (busData != dataAtFall) unstable++;
        if (!wrN) begin
          if (!leadSet) begin lead = csRun - 1; leadSet = 1; end
          wrRun++;
        end
        highRun = 0;
      end else begin
        highRun++;
        if (!prevCs) begin
          writes++;
          lastCs = csRun; lastWr = wrRun; lastLead = lead;
          lastTail = csRun - lead - wrRun; lastGap = gapNow;
          if (dataAtFall != expData) dataBad++;
          expData = expData + 8'd1;
        end
      end
      prevCs = csN;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic cfgWrite(input int cs, input int ws, input int act, input int hold, input bit en);
    @(posedge clk); #1;
    cfgWe = 1'b1;
    cfgWdata = {cs[3:0], ws[3:0], act[3:0], hold[3:0], 3'b000, en};
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic trigWrite(input logic [4:0] v);
    @(posedge clk); #1;
    trigWe = 1'b1; trigWdata = v;
    @(posedge clk); #1;
    trigWe = 1'b0;
  endtask

  task automatic waitIrq(input string tag, input int limit);
    int base = irqCnt;
    int n = 0;
    while (irqCnt == base && n < limit) begin
      @(negedge clk); #1;
      n++;
    end
    if (irqCnt == base) chk({tag, " frame-done timeout"}, 0, 1);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 csN at reset", csN, 1);
    chk("R1 wrN at reset", wrN, 1);
    chk("R1 frameIrq at reset", frameIrq, 0);
    chk("R1 pixReady at reset", pixReady, 0);
    trigWrite(5'b00011);
    ticks(40);
    chk("R2 R1 no write while disabled after reset", writes, 0);
  endtask

  task automatic t_basic;
    int w0 = writes, i0 = irqCnt, h0 = hsCnt;
    cfgWrite(1, 2, 3, 1, 1'b1);
    colCount = 4'd3; lineCount = 4'd2;
    trigWrite(5'b00011);
    waitIrq("R6", 600);
    chk("R5 writes per frame 3x2", writes - w0, 6);
    chk("R10 one irq", irqCnt - i0, 1);
    chk("R3 cs low length", lastCs, 7);
    chk("R3 wr low length", lastWr, 3);
    chk("R3 wr lead", lastLead, 3);
    chk("R3 wr tail", lastTail, 1);
    chk("R4 cs gap between writes", lastGap, 1);
    chk("R4 handshakes per frame", hsCnt - h0, 6);
    ticks(80);
    chk("R7 no repeat frame after command", writes - w0, 6);
  endtask

  task automatic t_min_timing;
    int w0 = writes;
    cfgWrite(0, 0, 0, 0, 1'b1);
    colCount = 4'd4; lineCount = 4'd1;
    trigWrite(5'b00011);
    waitIrq("R3 min", 300);
    chk("R5 writes 4x1", writes - w0, 4);
    chk("R3 min cs low", lastCs, 1);
    chk("R3 active floor of 1", lastWr, 1);
    chk("R3 min lead", lastLead, 0);
    chk("R4 min gap", lastGap, 1);
  endtask

  task automatic t_max_timing;
    int w0 = writes;
    cfgWrite(15, 15, 15, 15, 1'b1);
    colCount = 4'd1; lineCount = 4'd1;
    trigWrite(5'b00011);
    waitIrq("R3 max", 300);
    chk("R5 single write", writes - w0, 1);
    chk("R3 max cs low", lastCs, 60);
    chk("R3 max lead", lastLead, 30);
    chk("R3 max wr", lastWr, 15);
    chk("R3 max tail", lastTail, 15);
  endtask

  task automatic t_drop_sw;
    int w0 = writes, i0 = irqCnt;
    cfgWrite(4, 4, 4, 4, 1'b1);
    colCount = 4'd2; lineCount = 4'd2;
    trigWrite(5'b00011);
    ticks(20);
    trigWrite(5'b00011);
    waitIrq("R9 sw", 600);
    ticks(150);
    chk("R9 sw retrigger dropped writes", writes - w0, 4);
    chk("R9 sw retrigger dropped irq", irqCnt - i0, 1);
  endtask

  task automatic t_mode_off;
    int w0 = writes;
    trigWrite(5'b00010);
    ticks(60);
    chk("R11 command without mode ignored", writes - w0, 0);
  endtask

  task automatic t_hw;
    int w0 = writes, i0 = irqCnt;
    teIn = 1'b0;
    trigWrite(5'b11010);
    ticks(60);
    chk("R8 sw command ignored in hw mode", writes - w0, 0);
    teIn = 1'b1;
    waitIrq("R8", 600);
    chk("R8 te edge frame", writes - w0, 4);
    ticks(100);
    chk("R8 te level no retrigger", writes - w0, 4);
    teIn = 1'b0; ticks(5);
    w0 = writes; i0 = irqCnt;
    teIn = 1'b1; ticks(20);
    teIn = 1'b0; ticks(4);
    teIn = 1'b1;
    waitIrq("R9 te", 600);
    ticks(150);
    chk("R9 te during frame dropped writes", writes - w0, 4);
    chk("R9 te during frame dropped irq", irqCnt - i0, 1);
    teIn = 1'b0;
  endtask

  task automatic t_disabled_stall;
    int w0 = writes;
    cfgWrite(1, 1, 1, 1, 1'b0);
    ticks(5);
    teIn = 1'b1; ticks(40);
    chk("R2 te ignored when disabled", writes - w0, 0);
    chk("R2 ready low when disabled", pixReady, 0);
    teIn = 1'b0;
    cfgWrite(1, 1, 1, 1, 1'b1);
    colCount = 4'd2; lineCount = 4'd1;
    pixValid = 1'b0;
    trigWrite(5'b00011);
    ticks(30);
    chk("R4 no write without valid", writes - w0, 0);
    chk("R4 ready while waiting", pixReady, 1);
    pixValid = 1'b1;
    waitIrq("R4 stall", 300);
    chk("R5 stalled frame writes", writes - w0, 2);
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    ticks(4);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_min_timing();
    t_max_timing();
    t_drop_sw();
    t_mode_off();
    t_hw();
    t_disabled_stall();
    chk("R10 irq aligned with last cs rise", irqBad, 0);
    chk("R4 ready never with cs low", readyErr, 0);
    chk("R3 bus data matches accepted pixels", dataBad, 0);
    chk("R3 bus data stable during write", unstable, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule